// File: doc/BRIEF.md
# Double-Buffered Serial Receive Path

This block turns a stream of sampled serial bits into parallel words for a CPU. It has two storage stages. A bit-collecting stage takes one bit per strobe, least significant bit first. A holding register keeps the last completed word until the CPU reads it. When an end-of-frame strobe arrives, the collected word moves into the holding register and a one-cycle receive interrupt fires. The collecting stage can take in the next frame while the CPU has not yet read the holding register. Oversampling, start-bit search and stop-bit checking happen upstream. This block only sees bits that are already qualified.

Three frame formats are supported: 7 data bits, 8 data bits, and 9 data bits. A ninth-bit flag sits beside the holding register. In the 8-bit format it holds the extra bit after the data, normally parity. In the 9-bit format it holds the data MSB. A completed frame that finds the holding register still full is an overrun. That frame is thrown away, and a sticky overrun flag is set. For multiprocessor networks, a wake-up filter in the 9-bit format suppresses the interrupt for frames whose ninth bit is 0.

The collecting stage is a state machine with three states:
- `SH_IDLE`: no bits held.
- `SH_COLLECT`: some bits held.
- `SH_SATURATED`: all nine bit positions filled, so further bits are ignored.

Its transitions are:
- first bit: `SH_IDLE` to `SH_COLLECT`.
- ninth bit: `SH_COLLECT` to `SH_SATURATED`.
- frame end: any state to `SH_IDLE`.

The holding stage has two states, `HB_EMPTY` and `HB_FULL`. Its transitions are:
- transfer: `HB_EMPTY` to `HB_FULL`.
- CPU read: `HB_FULL` to `HB_EMPTY`.
- read and transfer in the same cycle: stays in `HB_FULL` with the new word.
- overrun: stays in `HB_FULL` with the old word.

Top module: `serial_rx_dbuf`

## Requirements
- R1: After reset, hold_data, ninth_bit, rx_irq, overrun and buf_full are all 0.
- R2: Bits are collected least significant bit first. The i-th accepted bit (counting from 0) goes to position i of the frame word. The fmt encoding is: 2'b00 means 7 data bits, 2'b01 means 8 data bits, 2'b10 means 9 data bits, and 2'b11 behaves as 8 data bits.
- R3: In the 7-bit format, hold_data receives bits 0..6 with bit 7 of hold_data forced to 0. ninth_bit receives frame bit 7.
- R4: In the 8-bit and 9-bit formats, hold_data receives frame bits 0..7 and ninth_bit receives frame bit 8.
- R5: A transfer happens when frame_done is sampled while the holding stage is empty. On the same clock edge hold_data and ninth_bit update, buf_full goes to 1, and rx_irq is 1 for exactly that one cycle.
- R6: cpu_rd clears buf_full. If cpu_rd and frame_done are sampled in the same cycle, the read takes effect first, the frame is transferred, and no overrun occurs.
- R7: Bits keep being collected while buf_full is 1. If the CPU reads before frame_done, the frame is transferred normally.
- R8: frame_done sampled while full and without cpu_rd is an overrun. hold_data and ninth_bit keep their old values, rx_irq stays 0, overrun goes to 1, and the collected bits are discarded.
- R9: overrun stays 1 through CPU reads and later transfers. It returns to 0 only when ovr_clr is sampled; a new overrun in the same cycle wins over the clear.
- R10: In the 9-bit format with wake_en = 1, the transfer still happens but rx_irq pulses only if the received ninth bit is 1. wake_en has no effect in the other formats.
- R11: Bits after the ninth in one frame are ignored. Positions never received read as 0. The collecting stage is empty again after every frame_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_valid | input | 1 | One-cycle strobe: bit_data holds a sampled bit |
| bit_data | input | 1 | Sampled serial bit |
| frame_done | input | 1 | One-cycle strobe marking the end of a frame |
| fmt | input | 2 | Frame format select (see R2) |
| wake_en | input | 1 | Multiprocessor wake-up filter enable |
| cpu_rd | input | 1 | CPU read strobe for the holding register |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| hold_data | output | 8 | Holding register contents |
| ninth_bit | output | 1 | Ninth-bit flag (parity or data MSB) |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |
| overrun | output | 1 | Sticky overrun flag |
| buf_full | output | 1 | Holding register holds an unread word |

## Verification
The hardest state to reach from the ports is a frame that completes while the holding register is full, in its three variants. In the first, no read happens at all, which is a true overrun. In the second, the read falls in the exact cycle of frame_done. In the third, the read lands partway through the next frame's bits. The bench can hold back bit shifting, the end-of-frame strobe and the read strobe separately, so each variant is reached on purpose. The filtered wake-up case is also checked through hold_data and buf_full, because it produces no interrupt for the scoreboard to catch.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    typedef enum logic [1:0] {
        FMT_7  = 2'b00,
        FMT_8  = 2'b01,
        FMT_9  = 2'b10,
        FMT_8B = 2'b11
    } rx_fmt_e;

    typedef enum logic [1:0] {
        SH_IDLE      = 2'd0,
        SH_COLLECT   = 2'd1,
        SH_SATURATED = 2'd2
    } sh_state_e;

    typedef enum logic {
        HB_EMPTY = 1'b0,
        HB_FULL  = 1'b1
    } hb_state_e;

endpackage

// File: rtl/rxb_shifter.sv
module rxb_shifter
    import rxb_pkg::*;
#(
    parameter int FRAME_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_valid,
    input  logic               bit_data,
    input  logic               frame_done,
    output logic [FRAME_W-1:0] frame_word
);

    localparam int CNT_W = $clog2(FRAME_W + 1);

    sh_state_e          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [FRAME_W-1:0] word_q, word_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_IDLE: begin
                if (!frame_done && bit_valid) begin
                    state_d = (FRAME_W == 1) ? SH_SATURATED : SH_COLLECT;
                end
            end
            SH_COLLECT: begin
                if (frame_done) begin
                    state_d = SH_IDLE;
                end else if (bit_valid && cnt_q == CNT_W'(FRAME_W - 1)) begin
                    state_d = SH_SATURATED;
                end
            end
            SH_SATURATED: begin
                if (frame_done) begin
                    state_d = SH_IDLE;
                end
            end
            default: state_d = SH_IDLE;
        endcase
    end

    // datapath next values
    always_comb begin
        cnt_d  = cnt_q;
        word_d = word_q;
        if (frame_done) begin
            cnt_d  = '0;
            word_d = '0;
        end else if (bit_valid && state_q != SH_SATURATED) begin
            for (int i = 0; i < FRAME_W; i++) begin
                if (cnt_q == CNT_W'(i)) begin
                    word_d[i] = bit_data;
                end
            end
            cnt_d = cnt_q + 1'b1;
        end
    end

    // output / datapath register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            word_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            word_q <= word_d;
        end
    end

    assign frame_word = word_q;

    // R11
    shift_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (word_q == '0));

    // R11
    saturate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_SATURATED && bit_valid && !frame_done) |=> $stable(word_q));

endmodule

// File: rtl/rxb_holdbuf.sv
module rxb_holdbuf
    import rxb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [DATA_W:0]   frame_word,
    input  logic [1:0]        fmt,
    input  logic              wake_en,
    input  logic              cpu_rd,
    input  logic              ovr_clr,
    output logic [DATA_W-1:0] hold_data,
    output logic              ninth_bit,
    output logic              rx_irq,
    output logic              overrun,
    output logic              buf_full
);

    hb_state_e          state_q, state_d;
    rx_fmt_e            fmt_e;
    logic [DATA_W-1:0]  cand_data;
    logic               cand_ninth;
    logic               room, do_xfer, do_ovr, irq_ok;
    logic [DATA_W-1:0]  hold_q;
    logic               ninth_q, irq_q, ovr_q;

    assign fmt_e = rx_fmt_e'(fmt);

    // field extraction per format
    always_comb begin
        if (fmt_e == FMT_7) begin
            cand_data  = {1'b0, frame_word[DATA_W-2:0]};
            cand_ninth = frame_word[DATA_W-1];
        end else begin
            cand_data  = frame_word[DATA_W-1:0];
            cand_ninth = frame_word[DATA_W];
        end
    end

    assign room    = (state_q == HB_EMPTY) || cpu_rd;
    assign do_xfer = frame_done && room;
    assign do_ovr  = frame_done && !room;
    assign irq_ok  = !(fmt_e == FMT_9 && wake_en && !cand_ninth);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HB_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HB_EMPTY: begin
                if (do_xfer) state_d = HB_FULL;
            end
            HB_FULL: begin
                if (do_xfer)     state_d = HB_FULL;
                else if (cpu_rd) state_d = HB_EMPTY;
            end
            default: state_d = HB_EMPTY;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            ninth_q <= 1'b0;
            irq_q   <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            irq_q <= do_xfer && irq_ok;
            if (do_xfer) begin
                hold_q  <= cand_data;
                ninth_q <= cand_ninth;
            end
            if (do_ovr) begin
                ovr_q <= 1'b1;
            end else if (ovr_clr) begin
                ovr_q <= 1'b0;
            end
        end
    end

    assign hold_data = hold_q;
    assign ninth_bit = ninth_q;
    assign rx_irq    = irq_q;
    assign overrun   = ovr_q;
    assign buf_full  = (state_q == HB_FULL);

    // R5
    irq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> buf_full);

    // R8
    ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> ($stable(hold_q) && $stable(ninth_q) && !irq_q));

    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !ovr_clr) |=> ovr_q);

    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !frame_done) |=> !buf_full);

    // R10
    wake_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && fmt_e == FMT_9 && wake_en) |-> ninth_q);

endmodule

// File: rtl/serial_rx_dbuf.sv
module serial_rx_dbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_data,
    input  logic              frame_done,
    input  logic [1:0]        fmt,
    input  logic              wake_en,
    input  logic              cpu_rd,
    input  logic              ovr_clr,
    output logic [DATA_W-1:0] hold_data,
    output logic              ninth_bit,
    output logic              rx_irq,
    output logic              overrun,
    output logic              buf_full
);

    localparam int FRAME_W = DATA_W + 1;

    logic [FRAME_W-1:0] frame_word;

    rxb_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_valid  (bit_valid),
        .bit_data   (bit_data),
        .frame_done (frame_done),
        .frame_word (frame_word)
    );

    rxb_holdbuf #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_word (frame_word),
        .fmt        (fmt),
        .wake_en    (wake_en),
        .cpu_rd     (cpu_rd),
        .ovr_clr    (ovr_clr),
        .hold_data  (hold_data),
        .ninth_bit  (ninth_bit),
        .rx_irq     (rx_irq),
        .overrun    (overrun),
        .buf_full   (buf_full)
    );

endmodule

// File: tb/sim_serial_rx_dbuf.sv
module sim_serial_rx_dbuf;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_valid = 1'b0, bit_data = 1'b0, frame_done = 1'b0;
    logic [1:0] fmt = 2'b01;
    logic       wake_en = 1'b0, cpu_rd = 1'b0, ovr_clr = 1'b0;
    logic [7:0] hold_data;
    logic       ninth_bit, rx_irq, overrun, buf_full;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] d;
        logic       n;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    serial_rx_dbuf u0 (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
        .frame_done(frame_done), .fmt(fmt), .wake_en(wake_en), .cpu_rd(cpu_rd),
        .ovr_clr(ovr_clr), .hold_data(hold_data), .ninth_bit(ninth_bit),
        .rx_irq(rx_irq), .overrun(overrun), .buf_full(buf_full)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic expect_item(input logic [7:0] d, input logic n);
        exp_t e;
        e.d = d;
        e.n = n;
        exp_q.push_back(e);
    endtask

    task automatic shift_bits(input logic [15:0] bits, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            bit_valid = 1'b1;
            bit_data  = bits[i];
            @(negedge clk);
            bit_valid = 1'b0;
        end
    endtask

    task automatic end_frame(input logic rd_same);
        @(negedge clk);
        frame_done = 1'b1;
        cpu_rd     = rd_same;
        @(negedge clk);
        frame_done = 1'b0;
        cpu_rd     = 1'b0;
    endtask

    task automatic send_frame(input logic [15:0] bits, input int nbits, input logic rd_same);
        shift_bits(bits, nbits);
        end_frame(rd_same);
    endtask

    task automatic cpu_read();
        @(negedge clk);
        cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    // scoreboard monitor: every interrupt must match the oldest expected word (R5)
    always @(negedge clk) begin
        if (rst_n && rx_irq) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5/R8/R10 unexpected irq", int'(hold_data), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(hold_data == e.d, "R2 irq data", int'(hold_data), int'(e.d));
                check(ninth_bit == e.n, "R4 irq ninth", int'(ninth_bit), int'(e.n));
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual 0 expected 1 (run completed)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(hold_data == 8'h00 && ninth_bit == 1'b0, "R1 hold", int'(hold_data), 0);
        check(!rx_irq && !overrun && !buf_full, "R1 flags",
              int'({rx_irq, overrun, buf_full}), 0);

        // R2 R4: 8-bit format, parity bit 1
        fmt = 2'b01;
        expect_item(8'hA5, 1'b1);
        send_frame(16'h01A5, 9, 1'b0);
        check(buf_full == 1'b1, "R5 full after transfer", int'(buf_full), 1);
        cpu_read();
        check(buf_full == 1'b0, "R6 read clears full", int'(buf_full), 0);

        // R3: 7-bit format, eighth received bit goes to ninth flag
        fmt = 2'b00;
        expect_item(8'h35, 1'b1);
        send_frame(16'h00B5, 8, 1'b0);
        cpu_read();

        // R4: 9-bit format, wake off, MSB 0
        fmt = 2'b10;
        expect_item(8'h3C, 1'b0);
        send_frame(16'h003C, 9, 1'b0);
        cpu_read();

        // R10: 9-bit format, wake on, MSB 0 -> transfer without irq
        wake_en = 1'b1;
        send_frame(16'h0077, 9, 1'b0);
        check(hold_data == 8'h77, "R10 filtered data stored", int'(hold_data), 8'h77);
        check(buf_full == 1'b1, "R10 filtered full", int'(buf_full), 1);
        cpu_read();

        // R10: wake on, MSB 1 -> irq
        expect_item(8'h81, 1'b1);
        send_frame(16'h0181, 9, 1'b0);
        cpu_read();

        // R10: wake_en ignored in 8-bit format
        fmt = 2'b01;
        expect_item(8'h42, 1'b0);
        send_frame(16'h0042, 9, 1'b0);
        cpu_read();
        wake_en = 1'b0;

        // R8: overrun keeps old word
        expect_item(8'h11, 1'b0);
        send_frame(16'h0011, 9, 1'b0);
        send_frame(16'h0122, 9, 1'b0);
        check(overrun == 1'b1, "R8 overrun set", int'(overrun), 1);
        check(hold_data == 8'h11 && ninth_bit == 1'b0, "R8 hold kept", int'(hold_data), 8'h11);
        cpu_read();
        check(overrun == 1'b1, "R9 sticky after read", int'(overrun), 1);
        expect_item(8'h33, 1'b0);
        send_frame(16'h0033, 9, 1'b0);
        check(overrun == 1'b1, "R9 sticky after transfer", int'(overrun), 1);
        @(negedge clk);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        check(overrun == 1'b0, "R9 cleared", int'(overrun), 0);
        cpu_read();

        // R7: collect next frame while full, read mid-frame
        expect_item(8'h44, 1'b0);
        send_frame(16'h0044, 9, 1'b0);
        shift_bits(16'h0155, 5);
        cpu_read();
        shift_bits(16'h0155 >> 5, 4);
        expect_item(8'h55, 1'b1);
        end_frame(1'b0);
        check(overrun == 1'b0, "R7 no overrun", int'(overrun), 0);
        check(hold_data == 8'h55, "R7 new word", int'(hold_data), 8'h55);
        cpu_read();

        // R6: read in the same cycle as frame_done
        expect_item(8'h66, 1'b0);
        send_frame(16'h0066, 9, 1'b0);
        expect_item(8'h99, 1'b1);
        send_frame(16'h0199, 9, 1'b1);
        check(overrun == 1'b0, "R6 same-cycle read no overrun", int'(overrun), 0);
        check(buf_full == 1'b1, "R6 full after same-cycle", int'(buf_full), 1);
        cpu_read();

        // R11: extra bits ignored, short frame zero-filled
        expect_item(8'hA5, 1'b1);
        send_frame(16'h0DA5, 12, 1'b0);
        cpu_read();
        expect_item(8'h0F, 1'b0);
        send_frame(16'h000F, 4, 1'b0);
        cpu_read();

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R5 all expected irqs seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule